// File: doc/BRIEF.md
# Twisted-Pair Port Link and Transmit Supervisor

This block watches over one 10 Mb/s twisted-pair port. It keeps the link state from the decoded link-pulse events and receive activity. It corrects the receive polarity when inverted link pulses keep arriving. It stops a transmitter that stays on too long, and it raises the post-transmit collision test pulse. It also turns two three-level configuration inputs into the selected medium and the duplex mode. The analog front end supplies one-cycle events for each valid link pulse and a flag for each pulse that arrives reversed. The controller side sees link status, polarity, a transmit block and one combined collision line.

Two straps are captured only while reset is held. One enables the link test. The other enables the heartbeat. The whole block runs on a single clock, and each cycle of that clock is one timer tick (10 MHz nominally). Every time limit is a parameter counted in ticks. The defaults are 100 ms for link loss, 45 ms for the jabber trip, 500 ms to release, and 1 µs each for the heartbeat delay and the heartbeat width.

Top module: `tps_port_supervisor`

## Requirements
- R1: While `rst` is high, `strap_link_test` and `strap_heartbeat` are captured and `col_out` is 0. After reset, changes on the straps have no effect. `link_oe` shows the captured link-test strap. Reset leaves `pol_inv`=0, `tx_block`=0, and the internal link state failed.
- R2: With link test enabled and the link up, the link fails (`link_ok`=0) after LINK_LOSS_TICKS cycles with neither `lp_evt` nor `rx_pkt`. Either event restarts that interval.
- R3: A failed link comes back up on the LINK_PASS_PULSES-th consecutive `lp_evt` (default 2). With link test disabled at reset, `link_ok` is always 1.
- R4: `pol_inv` toggles on the POL_RUN_PULSES-th consecutive `lp_evt` that has `lp_inv`=1 (default 8). An `lp_evt` with `lp_inv`=0 restarts the run.
- R5: When `tx_en` stays high for JAB_TRIP_TICKS cycles, `tx_block` goes to 1. `col_out` is then held at 1 while `tx_block` is 1, in every duplex mode.
- R6: `tx_block` clears after UNJAB_TICKS consecutive cycles with `tx_en` low. Any high cycle of `tx_en` restarts that count.
- R7: When the heartbeat strap was high and `tx_en` falls while `tx_block`=0, `col_out` carries one pulse of exactly HB_WIDTH_TICKS cycles. The pulse starts about HB_DELAY_TICKS cycles after the fall. With the strap low, no pulse appears.
- R8: Each configuration input is coded 00=low, 01=high, 10 or 11=floating. Duplex floating gives test mode, and every other mode output is 0 in that case. With duplex low the port runs half duplex: media low selects AUI (`media_utp`=0), media high selects UTP, and media floating selects auto. With duplex high: media low gives `loopback`=1 with `media_utp`=0; media high gives full-duplex UTP; media floating gives auto with full duplex. Mode outputs follow one cycle after the inputs.
- R9: In auto mode `media_utp` follows `link_ok`. In auto full-duplex mode, a failed link also forces half duplex.
- R10: In full duplex, `col_media` does not reach `col_out` and `echo_en`=0. Heartbeat and jabber still drive `col_out`. In half duplex, `col_media` drives `col_out`, and `echo_en`=1 whenever `full_dup`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one timer tick per cycle |
| rst | input | 1 | Synchronous active-high reset; straps are captured while it is high |
| strap_link_test | input | 1 | Link-test enable strap |
| strap_heartbeat | input | 1 | Heartbeat enable strap |
| cfg_duplex | input | 2 | Three-level duplex/test configuration |
| cfg_media | input | 2 | Three-level medium configuration |
| lp_evt | input | 1 | One-cycle valid link pulse received |
| lp_inv | input | 1 | That link pulse arrived with reversed polarity |
| rx_pkt | input | 1 | Receive packet activity |
| tx_en | input | 1 | Transmit enable from the controller |
| col_media | input | 1 | Collision sensed on the medium |
| link_ok | output | 1 | Link status |
| link_oe | output | 1 | Link status pin is driven (link test enabled) |
| pol_inv | output | 1 | Receive polarity correction is active |
| tx_block | output | 1 | Transmission disabled by jabber |
| col_out | output | 1 | Collision indication to the controller |
| media_utp | output | 1 | 1 = twisted pair selected, 0 = AUI |
| full_dup | output | 1 | Full duplex active |
| loopback | output | 1 | Loopback mode |
| test_mode | output | 1 | Test mode |
| echo_en | output | 1 | Internal echo of transmit data is allowed |

## Verification
A wrong link counter shows up at `link_ok` as a failure or recovery that lands cycles early or late. In auto mode it also shows up one cycle later as a wrong `media_utp`. A slip in the polarity run count shows on `pol_inv` right after the offending pulse. Jabber and release errors move the `tx_block` edge against the counted tick window. A heartbeat fault changes the width or the start of the `col_out` pulse within a few tens of cycles of the `tx_en` fall. Duplex masking errors leak `col_media` onto `col_out` two cycles after a mode change.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [1:0] {
    TRI_LO  = 2'd0,
    TRI_HI  = 2'd1,
    TRI_FLT = 2'd2
  } tri_t;

  typedef struct packed {
    logic utp;
    logic full;
    logic loop;
    logic test;
  } mode_t;

  function automatic tri_t tri_decode(input logic [1:0] raw);
    case (raw)
      2'd0:    return TRI_LO;
      2'd1:    return TRI_HI;
      default: return TRI_FLT;
    endcase
  endfunction
endpackage

// File: rtl/tps_link_mon.sv
module tps_link_mon #(
  parameter int LOSS_TICKS = 1000000,
  parameter int PASS_PULSES = 2,
  parameter int POL_PULSES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic lte,
  input  logic lp_evt,
  input  logic lp_inv,
  input  logic rx_pkt,
  output logic link_eff,
  output logic pol_inv
);
  localparam int IW = $clog2(LOSS_TICKS + 1);
  localparam int PW = $clog2(PASS_PULSES + 1);
  localparam int RW = $clog2(POL_PULSES + 1);
  localparam logic [IW-1:0] IDLE_MAX  = IW'(LOSS_TICKS - 1);
  localparam logic [PW-1:0] PASS_LAST = PW'(PASS_PULSES - 1);
  localparam logic [RW-1:0] RUN_LAST  = RW'(POL_PULSES - 1);

  logic [IW-1:0] idle_cnt;
  logic [PW-1:0] pass_cnt;
  logic [RW-1:0] run_cnt;
  logic          link_q;
  logic          pol_q;
  logic          activity;

  assign activity = lp_evt | rx_pkt;

  // link supervision: idle interval and recovery count
  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
      pass_cnt <= '0;
      link_q   <= 1'b0;
    end else begin
      if (activity) begin
        idle_cnt <= '0;
      end else if (idle_cnt != IDLE_MAX) begin
        idle_cnt <= idle_cnt + 1'b1;
      end
      if (!activity && idle_cnt == IDLE_MAX) begin
        link_q   <= 1'b0;
        pass_cnt <= '0;
      end else if (lp_evt && !link_q) begin
        if (pass_cnt == PASS_LAST) begin
          link_q   <= 1'b1;
          pass_cnt <= '0;
        end else begin
          pass_cnt <= pass_cnt + 1'b1;
        end
      end
    end
  end

  // polarity correction: run of reversed pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      pol_q   <= 1'b0;
    end else if (lp_evt) begin
      if (!lp_inv) begin
        run_cnt <= '0;
      end else if (run_cnt == RUN_LAST) begin
        run_cnt <= '0;
        pol_q   <= ~pol_q;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assign link_eff = lte ? link_q : 1'b1;
  assign pol_inv  = pol_q;

  p_link_rise_on_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(link_q) |-> $past(lp_evt));
  p_link_fall_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(link_q) |-> $past(!lp_evt && !rx_pkt));
  p_pol_flip_on_inverted_r4: assert property (@(posedge clk) disable iff (rst)
    (pol_q != $past(pol_q)) |-> $past(lp_evt && lp_inv));
endmodule

// File: rtl/tps_jab_hb.sv
module tps_jab_hb #(
  parameter int JAB_TICKS = 450000,
  parameter int UNJAB_TICKS = 5000000,
  parameter int HB_DELAY = 10,
  parameter int HB_WIDTH = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic hbe,
  input  logic tx_en,
  output logic jab,
  output logic hb_col
);
  localparam int JW = $clog2(JAB_TICKS + 1);
  localparam int UW = $clog2(UNJAB_TICKS + 1);
  localparam int HT = HB_DELAY + HB_WIDTH;
  localparam int HW = $clog2(HT + 1);
  localparam logic [JW-1:0] JAB_LAST   = JW'(JAB_TICKS - 1);
  localparam logic [UW-1:0] UNJAB_LAST = UW'(UNJAB_TICKS - 1);
  localparam logic [HW-1:0] HB_ON      = HW'(HB_DELAY);
  localparam logic [HW-1:0] HB_END     = HW'(HT);

  logic [JW-1:0] tx_cnt;
  logic [UW-1:0] unjab_cnt;
  logic [HW-1:0] hb_cnt;
  logic          jab_q;
  logic          tx_d;
  logic          hb_q;

  // jabber trip and release
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_cnt    <= '0;
      unjab_cnt <= '0;
      jab_q     <= 1'b0;
    end else if (!jab_q) begin
      unjab_cnt <= '0;
      if (!tx_en) begin
        tx_cnt <= '0;
      end else if (tx_cnt == JAB_LAST) begin
        tx_cnt <= '0;
        jab_q  <= 1'b1;
      end else begin
        tx_cnt <= tx_cnt + 1'b1;
      end
    end else begin
      tx_cnt <= '0;
      if (tx_en) begin
        unjab_cnt <= '0;
      end else if (unjab_cnt == UNJAB_LAST) begin
        unjab_cnt <= '0;
        jab_q     <= 1'b0;
      end else begin
        unjab_cnt <= unjab_cnt + 1'b1;
      end
    end
  end

  // heartbeat window after the end of a transmission
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_d   <= 1'b0;
      hb_cnt <= '0;
      hb_q   <= 1'b0;
    end else begin
      tx_d <= tx_en;
      if (tx_d && !tx_en && hbe && !jab_q) begin
        hb_cnt <= HW'(1);
      end else if (hb_cnt != '0) begin
        hb_cnt <= (hb_cnt == HB_END) ? '0 : hb_cnt + 1'b1;
      end
      hb_q <= (hb_cnt >= HB_ON) && (hb_cnt < HB_END);
    end
  end

  assign jab    = jab_q;
  assign hb_col = hb_q;

  p_jab_trip_needs_tx_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(jab_q) |-> $past(tx_en));
  p_unjab_needs_idle_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(jab_q) |-> $past(!tx_en));
  p_hb_only_enabled_r7: assert property (@(posedge clk) disable iff (rst)
    hb_q |-> hbe);
endmodule

// File: rtl/tps_mode_res.sv
module tps_mode_res
  import tps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] dup_raw,
  input  logic [1:0] med_raw,
  input  logic       link,
  output logic       media_utp,
  output logic       full_dup,
  output logic       loopback,
  output logic       test_mode,
  output logic       echo_en
);
  tri_t  dup_t;
  tri_t  med_t;
  mode_t nxt;
  mode_t cur;

  assign dup_t = tri_decode(dup_raw);
  assign med_t = tri_decode(med_raw);

  always_comb begin
    nxt = '0;
    case (dup_t)
      TRI_LO: begin
        case (med_t)
          TRI_LO:  nxt.utp = 1'b0;
          TRI_HI:  nxt.utp = 1'b1;
          default: nxt.utp = link;
        endcase
      end
      TRI_HI: begin
        case (med_t)
          TRI_LO:  nxt.loop = 1'b1;
          TRI_HI: begin
            nxt.utp  = 1'b1;
            nxt.full = 1'b1;
          end
          default: begin
            nxt.utp  = link;
            nxt.full = link;
          end
        endcase
      end
      default: nxt.test = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= '0;
    else     cur <= nxt;
  end

  assign media_utp = cur.utp;
  assign full_dup  = cur.full;
  assign loopback  = cur.loop;
  assign test_mode = cur.test;
  assign echo_en   = ~cur.full;

  p_full_needs_utp_r8: assert property (@(posedge clk) disable iff (rst)
    full_dup |-> (media_utp && !loopback && !test_mode));
  p_auto_fail_half_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(med_t == TRI_FLT) && !$past(link)) |-> (!full_dup && !media_utp));
endmodule

// File: rtl/tps_port_supervisor.sv
module tps_port_supervisor #(
  parameter int LINK_LOSS_TICKS = 1000000,
  parameter int LINK_PASS_PULSES = 2,
  parameter int POL_RUN_PULSES = 8,
  parameter int JAB_TRIP_TICKS = 450000,
  parameter int UNJAB_TICKS = 5000000,
  parameter int HB_DELAY_TICKS = 10,
  parameter int HB_WIDTH_TICKS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_link_test,
  input  logic       strap_heartbeat,
  input  logic [1:0] cfg_duplex,
  input  logic [1:0] cfg_media,
  input  logic       lp_evt,
  input  logic       lp_inv,
  input  logic       rx_pkt,
  input  logic       tx_en,
  input  logic       col_media,
  output logic       link_ok,
  output logic       link_oe,
  output logic       pol_inv,
  output logic       tx_block,
  output logic       col_out,
  output logic       media_utp,
  output logic       full_dup,
  output logic       loopback,
  output logic       test_mode,
  output logic       echo_en
);
  logic lte_q;
  logic hbe_q;
  logic link_eff;
  logic jab;
  logic hb_col;
  logic col_q;

  // straps are only looked at while reset is held
  always_ff @(posedge clk) begin
    if (rst) begin
      lte_q <= strap_link_test;
      hbe_q <= strap_heartbeat;
    end
  end

  tps_link_mon #(
    .LOSS_TICKS (LINK_LOSS_TICKS),
    .PASS_PULSES(LINK_PASS_PULSES),
    .POL_PULSES (POL_RUN_PULSES)
  ) i_link (
    .clk     (clk),
    .rst     (rst),
    .lte     (lte_q),
    .lp_evt  (lp_evt),
    .lp_inv  (lp_inv),
    .rx_pkt  (rx_pkt),
    .link_eff(link_eff),
    .pol_inv (pol_inv)
  );

  tps_jab_hb #(
    .JAB_TICKS  (JAB_TRIP_TICKS),
    .UNJAB_TICKS(UNJAB_TICKS),
    .HB_DELAY   (HB_DELAY_TICKS),
    .HB_WIDTH   (HB_WIDTH_TICKS)
  ) i_jab (
    .clk   (clk),
    .rst   (rst),
    .hbe   (hbe_q),
    .tx_en (tx_en),
    .jab   (jab),
    .hb_col(hb_col)
  );

  tps_mode_res i_mode (
    .clk      (clk),
    .rst      (rst),
    .dup_raw  (cfg_duplex),
    .med_raw  (cfg_media),
    .link     (link_eff),
    .media_utp(media_utp),
    .full_dup (full_dup),
    .loopback (loopback),
    .test_mode(test_mode),
    .echo_en  (echo_en)
  );

  // combined collision line: medium collisions masked in full duplex
  always_ff @(posedge clk) begin
    if (rst) col_q <= 1'b0;
    else     col_q <= (col_media & ~full_dup) | hb_col | jab;
  end

  assign col_out  = col_q;
  assign link_ok  = link_eff;
  assign link_oe  = lte_q;
  assign tx_block = jab;

  p_jab_drives_col_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_block && $past(tx_block)) |-> col_out);
  p_fdx_masks_media_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(full_dup) && !$past(hb_col) && !$past(jab)) |-> !col_out);
endmodule

// File: tb/test_tps_port_supervisor.sv
module test_tps_port_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int LOSS = 200;
  localparam int PASS = 2;
  localparam int POLN = 8;
  localparam int JAB = 300;
  localparam int UNJAB = 600;
  localparam int HBD = 10;
  localparam int HBW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_link_test = 1'b1, strap_heartbeat = 1'b1;
  logic [1:0] cfg_duplex = 2'd0, cfg_media = 2'd1;
  logic lp_evt = 1'b0, lp_inv = 1'b0, rx_pkt = 1'b0, tx_en = 1'b0, col_media = 1'b0;
  logic link_ok, link_oe, pol_inv, tx_block, col_out;
  logic media_utp, full_dup, loopback, test_mode, echo_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit exp_pol = 1'b0;
  int run = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tps_port_supervisor #(
    .LINK_LOSS_TICKS(LOSS), .LINK_PASS_PULSES(PASS), .POL_RUN_PULSES(POLN),
    .JAB_TRIP_TICKS(JAB), .UNJAB_TICKS(UNJAB),
    .HB_DELAY_TICKS(HBD), .HB_WIDTH_TICKS(HBW)
  ) i_tps_port_supervisor (
    .clk(clk), .rst(rst), .strap_link_test(strap_link_test),
    .strap_heartbeat(strap_heartbeat), .cfg_duplex(cfg_duplex), .cfg_media(cfg_media),
    .lp_evt(lp_evt), .lp_inv(lp_inv), .rx_pkt(rx_pkt), .tx_en(tx_en),
    .col_media(col_media), .link_ok(link_ok), .link_oe(link_oe), .pol_inv(pol_inv),
    .tx_block(tx_block), .col_out(col_out), .media_utp(media_utp), .full_dup(full_dup),
    .loopback(loopback), .test_mode(test_mode), .echo_en(echo_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit inv);
    @(negedge clk);
    lp_evt = 1'b1;
    lp_inv = inv;
    @(negedge clk);
    lp_evt = 1'b0;
    lp_inv = 1'b0;
  endtask

  // bench model of the polarity run counter (R4)
  task automatic pol_pulse(input bit inv);
    pulse(inv);
    if (!inv) run = 0;
    else if (run == POLN - 1) begin run = 0; exp_pol = ~exp_pol; end
    else run++;
  endtask

  // expected {utp, full, loop, test} from the mode table (R8, R9)
  function automatic logic [3:0] exp_mode(input logic [1:0] d, input logic [1:0] m, input logic lk);
    logic mf;
    mf = m[1];
    if (d[1]) return 4'b0001;
    if (d == 2'd0) return {(mf ? lk : m[0]), 3'b000};
    if (mf) return {lk, lk, 2'b00};
    if (m[0]) return 4'b1100;
    return 4'b0010;
  endfunction

  task automatic hb_measure(output int first, output int width);
    first = 0;
    width = 0;
    @(negedge clk);
    tx_en = 1'b1;
    wait_n(20);
    tx_en = 1'b0;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (col_out) begin
        if (first == 0) first = i;
        width++;
      end
    end
  endtask

  task automatic do_reset(input bit lte, input bit hbe);
    @(negedge clk);
    rst = 1'b1;
    strap_link_test = lte;
    strap_heartbeat = hbe;
    wait_n(3);
    chk("R1 col_out low in reset", col_out, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int first, width, seed, r;
    logic [1:0] d, m;
    logic [3:0] e;
    seed = 32'h5eed;
    r = $urandom(seed);

    // reset state (R1)
    do_reset(1'b1, 1'b1);
    chk("R1 link_ok after reset", link_ok, 0);
    chk("R1 link_oe strap", link_oe, 1);
    chk("R1 pol_inv after reset", pol_inv, 0);
    chk("R1 tx_block after reset", tx_block, 0);
    strap_link_test = 1'b0;
    strap_heartbeat = 1'b0;
    wait_n(5);
    chk("R1 strap ignored after reset", link_oe, 1);
    chk("R1 link unaffected by strap", link_ok, 0);

    // recovery (R3)
    pulse(1'b0);
    chk("R3 one pulse not enough", link_ok, 0);
    pulse(1'b0);
    chk("R3 second pulse passes", link_ok, 1);

    // loss (R2): last pulse registered one edge before the current negedge
    wait_n(LOSS - 4);
    chk("R2 link still up before limit", link_ok, 1);
    wait_n(6);
    chk("R2 link fails after limit", link_ok, 0);
    pulse(1'b0);
    pulse(1'b0);
    chk("R3 relink", link_ok, 1);
    for (int k = 0; k < 4; k++) begin
      wait_n(LOSS - 20);
      rx_pkt = 1'b1;
      @(negedge clk);
      rx_pkt = 1'b0;
    end
    chk("R2 rx_pkt keeps link", link_ok, 1);

    // polarity directed (R4)
    for (int k = 0; k < POLN - 1; k++) pol_pulse(1'b1);
    pol_pulse(1'b0);
    for (int k = 0; k < POLN - 1; k++) pol_pulse(1'b1);
    chk("R4 broken run no toggle", pol_inv, 0);
    pol_pulse(1'b1);
    chk("R4 full run toggles", pol_inv, 1);
    // polarity random (R4)
    for (int k = 0; k < 80; k++) begin
      pol_pulse(($urandom % 5) != 0);
      chk("R4 random pulse polarity", pol_inv, exp_pol);
    end

    // random modes with link up, then down (R8, R9)
    for (int k = 0; k < 30; k++) begin
      d = 2'($urandom % 4);
      m = 2'($urandom % 4);
      cfg_duplex = d;
      cfg_media = m;
      pulse(1'b0);
      wait_n(1);
      e = exp_mode(d, m, 1'b1);
      chk("R8 mode link up", {media_utp, full_dup, loopback, test_mode}, e);
      chk("R10 echo follows duplex", echo_en, !e[2]);
    end
    wait_n(LOSS + 5);
    chk("R2 link down for auto test", link_ok, 0);
    for (int k = 0; k < 30; k++) begin
      d = 2'($urandom % 4);
      m = 2'($urandom % 4);
      if (k < 2) begin d = 2'(k); m = 2'd2; end
      cfg_duplex = d;
      cfg_media = m;
      wait_n(2);
      e = exp_mode(d, m, 1'b0);
      chk("R9 mode link down", {media_utp, full_dup, loopback, test_mode}, e);
    end

    // heartbeat in half duplex (R7)
    cfg_duplex = 2'd0;
    cfg_media = 2'd1;
    hb_measure(first, width);
    chk("R7 heartbeat width", width, HBW);
    chk("R7 heartbeat delay window", (first >= HBD && first <= HBD + 3), 1);

    // collision masking (R10)
    col_media = 1'b1;
    wait_n(3);
    chk("R10 half duplex passes collision", col_out, 1);
    cfg_duplex = 2'd1;
    wait_n(3);
    chk("R10 full duplex masks collision", col_out, 0);
    chk("R10 echo off in full duplex", echo_en, 0);
    hb_measure(first, width);
    chk("R10 heartbeat kept in full duplex", width, HBW);

    // jabber in full duplex (R5, R6)
    @(negedge clk);
    tx_en = 1'b1;
    wait_n(JAB - 3);
    chk("R5 no trip before limit", tx_block, 0);
    wait_n(6);
    chk("R5 trip after limit", tx_block, 1);
    wait_n(50);
    chk("R5 col_out during jabber", col_out, 1);
    tx_en = 1'b0;
    wait_n(UNJAB / 2);
    tx_en = 1'b1;
    @(negedge clk);
    tx_en = 1'b0;
    wait_n(UNJAB - 5);
    chk("R6 restart of release count", tx_block, 1);
    wait_n(10);
    chk("R6 released", tx_block, 0);
    col_media = 1'b0;

    // link test and heartbeat disabled (R3, R7, R9)
    cfg_duplex = 2'd0;
    cfg_media = 2'd2;
    do_reset(1'b0, 1'b0);
    wait_n(2);
    chk("R3 link forced up without link test", link_ok, 1);
    chk("R1 link_oe low", link_oe, 0);
    chk("R9 auto picks UTP", media_utp, 1);
    hb_measure(first, width);
    chk("R7 no heartbeat when disabled", width, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule